// File: doc/BRIEF.md
# Complementary Half-Bridge PWM with Dead Time

This block is a 12-bit up-counting PWM timer that drives two outputs for a half-bridge: a high-side signal and a low-side signal. Each period starts from a programmable reload value and ends at the all-ones count. A compare value splits the period into an active part and an idle part. Software writes the reload, compare, dead-time and polarity settings through simple write strobes. The timer advances only on cycles where the tick-enable input is high, so an outside prescaler sets the tick rate.

When dead time is switched on, each rising edge is held back by a set number of ticks. The low-side output rises that many ticks after the compare match. The high-side output rises that many ticks after the reload. Both falling edges keep their normal positions, so the two switches are never on together.

The dead-time setting has a shadow copy. A new value is used only from the next overflow onwards, so the period already running is never cut short or stretched. Each output has its own inversion bit, applied as the last step.

Top module: `halfbridge_pwm`

## Requirements
- R1: The count advances by one only on cycles where `tick_en` is high. On a tick at count 4095, `wrap` is high for that cycle, and the count takes the reload value at the clock edge.
- R2: After reset, and until the first wrap, both outputs sit at their inactive level (low before inversion). Every setting register, including the dead-time shadow, is cleared by reset.
- R3: With the dead-time enable (bit 7 of `dt_din`) clear in the shadow, `hs_out` is high while count < compare, and `ls_out` is its exact complement with no delay.
- R4: With the dead-time enable set and a nonzero length L (bits 6:0), `hs_out` is high while count ≥ reload + L and count < compare. Its rise therefore comes L ticks after the reload.
- R5: In the same mode, `ls_out` is high while count ≥ compare + L. Its rise therefore comes L ticks after the compare match, and it falls at the reload.
- R6: With the dead-time enable set and length 0, both outputs stay at their inactive level.
- R7: A written dead-time byte goes into the shadow only on a wrap tick. The period in progress keeps using the old value.
- R8: `pol_din` bit 0 inverts `hs_out` and bit 1 inverts `ls_out`. Inversion is applied after dead-time shaping and takes effect on the next clock edge.
- R9: With dead time active and no inversion, the two outputs are never high in the same cycle. This holds even when L is longer than the active or idle part of the period; in that case the delayed rise simply never happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter tick enable |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_din | input | 12 | Reload value |
| cmp_wr | input | 1 | Write strobe for the compare value |
| cmp_din | input | 12 | Compare value |
| dt_wr | input | 1 | Write strobe for the dead-time byte |
| dt_din | input | 8 | Bit 7 is the enable, bits 6:0 are the length in ticks |
| pol_wr | input | 1 | Write strobe for the polarity bits |
| pol_din | input | 2 | Bit 0 inverts hs_out, bit 1 inverts ls_out |
| hs_out | output | 1 | High-side PWM output |
| ls_out | output | 1 | Low-side PWM output |
| wrap | output | 1 | One-cycle overflow indication |

## Verification
The embedded assertions check the following on every cycle:
- the count holds while ticks are off and lands on the reload after each wrap;
- the shadow changes only on a wrap;
- the outputs never overlap with dead time active;
- the outputs stay inactive before the first wrap and with a zero length;
- the outputs are complementary with dead time disabled.

Other properties can only be shown by the bench's scenarios:
- the exact widths of the delayed high and low intervals;
- the cancelled rise when the length exceeds an interval;
- the one-period lag of a dead-time rewrite;
- the effect of inversion on pulse widths;
- the stretched period under gapped ticks.

// File: rtl/halfbridge_pwm.sv
module halfbridge_pwm #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 7,
  parameter logic [CNT_W-1:0] RESET_RELOAD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_din,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_din,
  input  logic             dt_wr,
  input  logic [DT_W:0]    dt_din,
  input  logic             pol_wr,
  input  logic [1:0]       pol_din,
  output logic             hs_out,
  output logic             ls_out,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam int EXT = CNT_W + 1 - DT_W;

  logic [CNT_W-1:0] cnt_q, reload_q, cmp_q;
  logic [DT_W:0]    dt_q, dt_sh;
  logic [1:0]       pol_q;
  logic             run_q;

  wire tick_top = tick_en && (cnt_q == TOP);
  assign wrap = tick_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cmp_q    <= '0;
      dt_q     <= '0;
      pol_q    <= '0;
    end else begin
      if (reload_wr) reload_q <= reload_din;
      if (cmp_wr)    cmp_q    <= cmp_din;
      if (dt_wr)     dt_q     <= dt_din;
      if (pol_wr)    pol_q    <= pol_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RESET_RELOAD;
      dt_sh <= '0;
      run_q <= 1'b0;
    end else if (tick_en) begin
      if (tick_top) begin
        cnt_q <= reload_q;
        dt_sh <= dt_q;
        run_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  wire            dt_on  = dt_sh[DT_W];
  wire [DT_W-1:0] dt_len = dt_sh[DT_W-1:0];
  wire [CNT_W:0]  len_x  = {{EXT{1'b0}}, dt_len};
  wire [CNT_W:0]  cnt_x  = {1'b0, cnt_q};
  wire [CNT_W:0]  hs_rise = {1'b0, reload_q} + len_x;
  wire [CNT_W:0]  ls_rise = {1'b0, cmp_q} + len_x;
  wire            active = cnt_q < cmp_q;

  logic hs_core, ls_core;
  always_comb begin
    hs_core = 1'b0;
    ls_core = 1'b0;
    if (run_q) begin
      if (!dt_on) begin
        hs_core = active;
        ls_core = !active;
      end else if (dt_len != '0) begin
        hs_core = active && (cnt_x >= hs_rise);
        ls_core = cnt_x >= ls_rise;
      end
    end
  end

  assign hs_out = hs_core ^ pol_q[0];
  assign ls_out = ls_core ^ pol_q[1];

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
  // R1
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == $past(reload_q)));
  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(dt_sh));
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_on && pol_q == 2'b00) |-> !(hs_out && ls_out));
  // R6
  zero_len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_on && dt_len == '0) |-> (hs_out == pol_q[0] && ls_out == pol_q[1]));
  // R3
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !dt_on) |-> ((hs_out ^ ls_out) == !(pol_q[0] ^ pol_q[1])));
  // R2
  startup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (hs_out == pol_q[0] && ls_out == pol_q[1]));

endmodule

// File: tb/halfbridge_pwm_tb_top.sv
module halfbridge_pwm_tb_top;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n = 0, tick_en = 0, reload_wr = 0, cmp_wr = 0, dt_wr = 0, pol_wr = 0;
  logic [11:0] reload_din = 0, cmp_din = 0;
  logic [7:0]  dt_din = 0;
  logic [1:0]  pol_din = 0;
  logic hs_out, ls_out, wrap;
  int checks = 0, fails = 0;
  bit alt = 0;

  halfbridge_pwm dut_i (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .reload_wr(reload_wr), .reload_din(reload_din), .cmp_wr(cmp_wr), .cmp_din(cmp_din),
    .dt_wr(dt_wr), .dt_din(dt_din), .pol_wr(pol_wr), .pol_din(pol_din),
    .hs_out(hs_out), .ls_out(ls_out), .wrap(wrap));

  // reference model built from the requirements
  logic [11:0] m_cnt, m_rl, m_cmp;
  logic [7:0]  m_dt, m_sh;
  logic [1:0]  m_pol;
  logic        m_run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_rl <= 0; m_cmp <= 0; m_dt <= 0; m_sh <= 0; m_pol <= 0; m_run <= 0;
    end else begin
      if (reload_wr) m_rl <= reload_din;
      if (cmp_wr) m_cmp <= cmp_din;
      if (dt_wr) m_dt <= dt_din;
      if (pol_wr) m_pol <= pol_din;
      if (tick_en) begin
        if (m_cnt == 12'hFFF) begin m_cnt <= m_rl; m_sh <= m_dt; m_run <= 1; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  function automatic logic [1:0] model_out();
    int c = m_cnt, r = m_rl, d = m_cmp, t = m_sh[6:0];
    logic h = 0, l = 0;
    if (m_run) begin
      if (!m_sh[7]) begin h = (c < d); l = !h; end
      else if (t != 0) begin h = (c >= r + t) && (c < d); l = (c >= d + t); end
    end
    return {l ^ m_pol[1], h ^ m_pol[0]};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    // R4 R5 R9: cycle-by-cycle output shape against the model
    check("R4/R5 outputs", {ls_out, hs_out}, model_out());
    check("R1 wrap", wrap, tick_en && m_cnt == 12'hFFF);
    if (m_sh[7] && m_pol == 0) check("R9 overlap", hs_out && ls_out, 0);
  end

  always @(negedge clk) begin
    #2; if (alt) tick_en = ~tick_en;
  end

  task automatic step(); @(negedge clk); #2; endtask

  task automatic write_all(int rl, int cp, int dt, int pl);
    step();
    reload_wr = 1; reload_din = rl[11:0]; cmp_wr = 1; cmp_din = cp[11:0];
    dt_wr = 1; dt_din = dt[7:0]; pol_wr = 1; pol_din = pl[1:0];
    step();
    reload_wr = 0; cmp_wr = 0; dt_wr = 0; pol_wr = 0;
  endtask

  task automatic wait_wrap(); do @(negedge clk); while (!wrap); endtask

  task automatic measure(output int h, output int l);
    h = 0; l = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); h += hs_out; l += ls_out; end
  endtask

  localparam int NV = 7;
  localparam int V_CMP [NV] = '{4064, 4064, 4040, 4090, 4064, 4064, 4048};
  localparam int V_DT  [NV] = '{8'h00, 8'h85, 8'h8A, 8'h8A, 8'h80, 8'h85, 8'h03};
  localparam int V_POL [NV] = '{0, 0, 0, 0, 0, 3, 0};
  localparam int V_HI0 [NV] = '{32, 27, 0, 48, 0, 37, 16};
  localparam int V_HI1 [NV] = '{32, 27, 46, 0, 0, 37, 48};
  localparam string V_REQ [NV] = '{"R3", "R4", "R9", "R9", "R6", "R8", "R3"};

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int h, l, gap;
    logic hs0, ls0;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset hs", hs_out, 0);
    check("R2 reset ls", ls_out, 0);
    check("R2 reset wrap", wrap, 0);
    rst_n = 1; tick_en = 1;
    write_all(4032, 2048, 0, 0);
    repeat (10) @(negedge clk);
    check("R2 idle hs before first wrap", hs_out, 0);
    check("R2 idle ls before first wrap", ls_out, 0);

    for (int v = 0; v < NV; v++) begin
      write_all(4032, V_CMP[v], V_DT[v], V_POL[v]);
      wait_wrap();
      measure(h, l);
      check({V_REQ[v], " R4 hs width"}, h, V_HI0[v]);
      check({V_REQ[v], " R5 ls width"}, l, V_HI1[v]);
    end

    // R7: a dead-time rewrite waits for the wrap
    write_all(4032, 4064, 8'h85, 0);
    wait_wrap();
    h = 0; l = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); h += hs_out; l += ls_out;
      #2;
      if (i == 0) begin dt_wr = 1; dt_din = 8'h80; end
      else dt_wr = 0;
    end
    check("R7 old length kept hs", h, 27);
    check("R7 old length kept ls", l, 27);
    measure(h, l);
    check("R7 new length after wrap hs", h, 0);
    check("R7 new length after wrap ls", l, 0);

    // R1: ticks stopped hold everything
    write_all(4032, 4064, 8'h00, 0);
    wait_wrap(); repeat (20) @(negedge clk);
    #2; tick_en = 0; @(negedge clk);
    hs0 = hs_out; ls0 = ls_out;
    repeat (20) @(negedge clk);
    check("R1 stall hs", hs_out, hs0);
    check("R1 stall ls", ls_out, ls0);
    check("R1 stall wrap", wrap, 0);

    // R1: every other cycle a tick doubles the period
    #2; tick_en = 1; alt = 1;
    wait_wrap();
    @(negedge clk);
    check("R1 wrap one cycle", wrap, 0);
    gap = 1;
    while (!wrap) begin @(negedge clk); gap++; end
    check("R1 gapped period", gap, 128);
    alt = 0; #3; tick_en = 1;

    // R2: reset in mid-run
    write_all(4032, 4064, 8'h00, 0);
    step(); rst_n = 0;
    @(negedge clk);
    check("R2 mid-run reset hs", hs_out, 0);
    check("R2 mid-run reset ls", ls_out, 0);
    check("R2 mid-run reset wrap", wrap, 0);
    finish_run();
  end
endmodule